// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Status Capture

This block sits at the end of a page-table walk in a memory management unit. It receives the finished walk's result for one request: the 3-bit access field of the final page entry and any walk error. With that it gets the request type (load, store or instruction fetch), whether the requester runs in supervisor state, the virtual address, a no-fault control bit and the trap-enable state. It decides which rights the access gets and whether a trap is raised. One cycle after a request it reports the granted read, write and execute rights and a grant flag. A trap appears as a one-cycle pulse on the instruction-fault or the data-fault output.

Each recorded fault is written into a fault status register, and its virtual address goes into a fault address register. Both are always visible at the ports. The status word packs the walk level, a 3-bit access index, the error type and a constant marker bit. A second fault that arrives before software has read the status word is flagged as an overflow. A software read strobe returns the status value in that cycle and clears the register at the following edge. No-fault mode and disabled traps let a faulting access proceed with full rights and without a trap. No-fault mode also hides permission errors for user-state requests entirely.

Top module: `mmu_access_guard`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is zero: rights, grant, response valid, both fault pulses, and both status registers.
- R2: The access index is {store, fetch, supervisor}, with the store flag as bit 2 and the supervisor flag as bit 0. `req_kind_i` codes are 0 load, 1 store, 2 fetch, and 3 is treated as a load. The permission error is looked up from an 8-by-8 table by index and access field. A protection error gives type 2 and a privilege error gives type 3.
- R3: An allowed access gets its rights from the field. In supervisor state fields 0..7 give R, RW, RX, RWX, X, RW, RX, RWX. In user state fields 0..4 give the same, field 5 gives R, and fields 6 and 7 give nothing. A granted write always comes with read.
- R4: With no-fault mode set, a permission error on a user-state request is ignored. No fault is recorded, both status registers are left unchanged, and the user rights of the field are granted.
- R5: A non-zero walk error kind is a fault whatever the access field holds. The status word then becomes level in bits [9:8], access index in bits [7:5], error type in bits [4:2], and 1 in bit 1.
- R6: If the status register is non-zero (and not being read) when a fault is recorded, its old content is replaced by 1. The new fault's fields are then OR'ed in, so bit 0 marks overflow.
- R7: The fault address register takes the request's virtual address when a fault is recorded and holds its value at every other time.
- R8: A recorded fault traps only when no-fault mode is clear and traps are enabled. A fetch pulses `ifault_o` and any other kind pulses `dfault_o`, for one cycle alongside the response. A trapping access gets no rights. A recorded fault that does not trap gets read, write and execute.
- R9: A read strobe clears the status register at the next edge. A fault recorded at that same edge is written fresh, without the overflow bit.
- R10: `rsp_ok_o` is high on every response except a trapping one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_super_i | input | 1 | Requester in supervisor state |
| req_vaddr_i | input | VA_W | Virtual address of the request |
| acc_field_i | input | 3 | Access field of the final page entry |
| walk_level_i | input | 2 | Table level where the walk stopped |
| walk_kind_i | input | 3 | Walk error type, 0 for a clean walk |
| nofault_en_i | input | 1 | No-fault mode control |
| traps_en_i | input | 1 | Traps enabled |
| fsr_rd_i | input | 1 | Software read strobe of the status register |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rd_o | output | 1 | Read right granted |
| rsp_wr_o | output | 1 | Write right granted |
| rsp_ex_o | output | 1 | Execute right granted |
| rsp_ok_o | output | 1 | Access proceeds |
| ifault_o | output | 1 | Instruction fault pulse |
| dfault_o | output | 1 | Data fault pulse |
| fsr_o | output | 10 | Fault status register |
| far_o | output | VA_W | Fault address register |

## Verification
The hardest case to reach is an edge where a software read and a new fault meet. At that edge the overflow rule must give way to the clear. The stimulus raises the read strobe in the same cycle as a faulting store, while the register still holds a prior overflowed fault. It checks the fresh word without bit 0 afterwards. A walk fault followed by a second fault with no read between them covers the overflow itself. The no-fault cases pair user and supervisor requests with the same error, which separates the ignored error from the recorded but non-trapping one.

// File: rtl/mag_pkg.sv
package mag_pkg;

    localparam int FIELD_W = 3;
    localparam int IDX_W   = 3;
    localparam int TYPE_W  = 3;
    localparam int LVL_W   = 2;
    localparam int NUM_FIELDS = 1 << FIELD_W;
    localparam int NUM_IDX    = 1 << IDX_W;
    localparam int TYPE_LSB = 2;
    localparam int IDX_LSB  = TYPE_LSB + TYPE_W;
    localparam int LVL_LSB  = IDX_LSB + IDX_W;
    localparam int FSR_W    = LVL_LSB + LVL_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    localparam logic [TYPE_W-1:0] ERR_NONE = 3'd0;
    localparam logic [TYPE_W-1:0] ERR_PROT = 3'd2;
    localparam logic [TYPE_W-1:0] ERR_PRIV = 3'd3;

    localparam rights_t RIGHTS_NONE = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
    localparam rights_t RIGHTS_ALL  = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};

    // Per index row: 2-bit code per field, field c at bits [2c+1:2c].
    // Code 0 allowed, 2 protection, 3 privilege.
    function automatic logic [2*NUM_FIELDS-1:0] err_row(input logic [IDX_W-1:0] idx);
        logic [2*NUM_FIELDS-1:0] r;
        case (idx)
            3'd0:    r = 16'hF200;
            3'd1:    r = 16'h0200;
            3'd2:    r = 16'hF80A;
            3'd3:    r = 16'h080A;
            3'd4:    r = 16'hFA22;
            3'd5:    r = 16'h2222;
            3'd6:    r = 16'hFA2A;
            default: r = 16'h2A2A;
        endcase
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] pack_index(input acc_kind_e kind, input logic sup);
        return {kind == ACC_STORE, kind == ACC_FETCH, sup};
    endfunction

    function automatic rights_t base_rights(input logic [FIELD_W-1:0] field);
        rights_t r;
        case (field)
            3'd0:    r = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
            3'd1:    r = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
            3'd2:    r = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            3'd3:    r = RIGHTS_ALL;
            3'd4:    r = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
            3'd5:    r = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
            3'd6:    r = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            default: r = RIGHTS_ALL;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mag_perm_lut.sv
module mag_perm_lut
    import mag_pkg::*;
#(
    parameter bit USER_RESTRICT = 1'b1
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               sup_i,
    output logic [TYPE_W-1:0]  err_type_o,
    output rights_t            rights_o
);
    logic [2*NUM_FIELDS-1:0] row;
    logic [1:0]              code;

    always_comb begin
        row  = err_row(idx_i);
        code = row[2*field_i +: 2];
        err_type_o = (code == 2'd0) ? ERR_NONE : {1'b0, code};
    end

    generate
        if (USER_RESTRICT) begin : g_user_table
            always_comb begin
                rights_o = base_rights(field_i);
                if (!sup_i) begin
                    if (field_i == 3'd5) begin
                        rights_o = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
                    end else if (field_i[2:1] == 2'b11) begin
                        rights_o = RIGHTS_NONE;
                    end
                end
            end
        end else begin : g_flat_table
            always_comb rights_o = base_rights(field_i);
        end
    endgenerate
endmodule

// File: rtl/mag_fault_decide.sv
module mag_fault_decide
    import mag_pkg::*;
(
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               sup_i,
    input  logic [TYPE_W-1:0]  perm_err_i,
    input  rights_t            perm_rights_i,
    input  logic [LVL_W-1:0]   walk_level_i,
    input  logic [TYPE_W-1:0]  walk_kind_i,
    input  logic               nofault_i,
    input  logic               traps_en_i,
    output logic               capture_o,
    output logic               trap_o,
    output logic [FSR_W-1:0]   code_o,
    output rights_t            rights_o
);
    logic              walk_bad;
    logic              perm_bad;
    logic [TYPE_W-1:0] err_type;
    logic [LVL_W-1:0]  err_lvl;

    always_comb begin
        walk_bad  = (walk_kind_i != ERR_NONE);
        perm_bad  = (perm_err_i != ERR_NONE) && !(nofault_i && !sup_i);
        capture_o = walk_bad || perm_bad;
        trap_o    = capture_o && !nofault_i && traps_en_i;
        err_type  = walk_bad ? walk_kind_i : perm_err_i;
        err_lvl   = walk_bad ? walk_level_i : '0;

        code_o = '0;
        code_o[LVL_LSB +: LVL_W]   = err_lvl;
        code_o[IDX_LSB +: IDX_W]   = idx_i;
        code_o[TYPE_LSB +: TYPE_W] = err_type;
        code_o[1]                  = 1'b1;

        if (trap_o) begin
            rights_o = RIGHTS_NONE;
        end else if (capture_o) begin
            rights_o = RIGHTS_ALL;
        end else begin
            rights_o = perm_rights_i;
        end
    end
endmodule

// File: rtl/mag_status_regs.sv
module mag_status_regs
    import mag_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic [FSR_W-1:0] code_i,
    input  logic [VA_W-1:0]  vaddr_i,
    input  logic             rd_i,
    output logic [FSR_W-1:0] fsr_o,
    output logic [VA_W-1:0]  far_o
);
    logic [FSR_W-1:0] fsr_q, fsr_d;
    logic [VA_W-1:0]  far_q;
    logic [FSR_W-1:0] base;

    always_comb begin
        base  = ((fsr_q != '0) && !rd_i) ? FSR_W'(1) : '0;
        fsr_d = fsr_q;
        if (capture_i) begin
            fsr_d = base | code_i;
        end else if (rd_i) begin
            fsr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q <= '0;
            far_q <= '0;
        end else begin
            fsr_q <= fsr_d;
            if (capture_i) begin
                far_q <= vaddr_i;
            end
        end
    end

    assign fsr_o = fsr_q;
    assign far_o = far_q;
endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
    import mag_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid_i,
    input  logic [1:0]          req_kind_i,
    input  logic                req_super_i,
    input  logic [VA_W-1:0]     req_vaddr_i,
    input  logic [FIELD_W-1:0]  acc_field_i,
    input  logic [LVL_W-1:0]    walk_level_i,
    input  logic [TYPE_W-1:0]   walk_kind_i,
    input  logic                nofault_en_i,
    input  logic                traps_en_i,
    input  logic                fsr_rd_i,
    output logic                rsp_valid_o,
    output logic                rsp_rd_o,
    output logic                rsp_wr_o,
    output logic                rsp_ex_o,
    output logic                rsp_ok_o,
    output logic                ifault_o,
    output logic                dfault_o,
    output logic [FSR_W-1:0]    fsr_o,
    output logic [VA_W-1:0]     far_o
);
    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic [TYPE_W-1:0] perm_err;
    rights_t           perm_rights;
    logic              capture, trap;
    logic [FSR_W-1:0]  code;
    rights_t           rights;

    rights_t rights_q;
    logic    valid_q, ok_q, ifault_q, dfault_q;

    assign kind = acc_kind_e'(req_kind_i);
    assign idx  = pack_index(kind, req_super_i);

    mag_perm_lut #(.USER_RESTRICT(1'b1)) u_lut (
        .idx_i      (idx),
        .field_i    (acc_field_i),
        .sup_i      (req_super_i),
        .err_type_o (perm_err),
        .rights_o   (perm_rights)
    );

    mag_fault_decide u_decide (
        .idx_i         (idx),
        .sup_i         (req_super_i),
        .perm_err_i    (perm_err),
        .perm_rights_i (perm_rights),
        .walk_level_i  (walk_level_i),
        .walk_kind_i   (walk_kind_i),
        .nofault_i     (nofault_en_i),
        .traps_en_i    (traps_en_i),
        .capture_o     (capture),
        .trap_o        (trap),
        .code_o        (code),
        .rights_o      (rights)
    );

    mag_status_regs #(.VA_W(VA_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .capture_i (req_valid_i && capture),
        .code_i    (code),
        .vaddr_i   (req_vaddr_i),
        .rd_i      (fsr_rd_i),
        .fsr_o     (fsr_o),
        .far_o     (far_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            rights_q <= RIGHTS_NONE;
            ok_q     <= 1'b0;
            ifault_q <= 1'b0;
            dfault_q <= 1'b0;
        end else begin
            valid_q  <= req_valid_i;
            rights_q <= req_valid_i ? rights : RIGHTS_NONE;
            ok_q     <= req_valid_i && !trap;
            ifault_q <= req_valid_i && trap && (kind == ACC_FETCH);
            dfault_q <= req_valid_i && trap && (kind != ACC_FETCH);
        end
    end

    assign rsp_valid_o = valid_q;
    assign rsp_rd_o    = rights_q.rd;
    assign rsp_wr_o    = rights_q.wr;
    assign rsp_ex_o    = rights_q.ex;
    assign rsp_ok_o    = ok_q;
    assign ifault_o    = ifault_q;
    assign dfault_o    = dfault_q;
endmodule

// File: rtl/mag_guard_chk.sv
module mag_guard_chk
    import mag_pkg::*;
#(
    parameter int VA_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid_i,
    input logic             fsr_rd_i,
    input logic             rsp_valid_o,
    input logic             rsp_rd_o,
    input logic             rsp_wr_o,
    input logic             rsp_ok_o,
    input logic             ifault_o,
    input logic             dfault_o,
    input logic [FSR_W-1:0] fsr_o,
    input logic [VA_W-1:0]  far_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (fsr_o == '0 && !rsp_valid_o && !ifault_o && !dfault_o));

    assert_write_needs_read_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_wr_o |-> rsp_rd_o);

    assert_trap_marks_fsr_R5: assert property (@(posedge clk) disable iff (rst)
        (ifault_o || dfault_o) |-> fsr_o[1]);

    assert_far_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid_i) |-> $stable(far_o));

    assert_pulse_with_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        (ifault_o || dfault_o) |-> (rsp_valid_o && !(ifault_o && dfault_o)));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(fsr_rd_i) && !$past(req_valid_i)) |-> (fsr_o == '0));

    assert_trap_denies_R10: assert property (@(posedge clk) disable iff (rst)
        (ifault_o || dfault_o) |-> !rsp_ok_o);
endmodule

bind mmu_access_guard mag_guard_chk #(.VA_W(VA_W)) u_guard_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .fsr_rd_i    (fsr_rd_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rd_o    (rsp_rd_o),
    .rsp_wr_o    (rsp_wr_o),
    .rsp_ok_o    (rsp_ok_o),
    .ifault_o    (ifault_o),
    .dfault_o    (dfault_o),
    .fsr_o       (fsr_o),
    .far_o       (far_o)
);

// File: tb/test_mmu_access_guard.sv
module test_mmu_access_guard;
    localparam int VA_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid_i = 1'b0;
    logic [1:0]      req_kind_i = '0;
    logic            req_super_i = 1'b0;
    logic [VA_W-1:0] req_vaddr_i = '0;
    logic [2:0]      acc_field_i = '0;
    logic [1:0]      walk_level_i = '0;
    logic [2:0]      walk_kind_i = '0;
    logic            nofault_en_i = 1'b0;
    logic            traps_en_i = 1'b1;
    logic            fsr_rd_i = 1'b0;
    logic            rsp_valid_o, rsp_rd_o, rsp_wr_o, rsp_ex_o, rsp_ok_o;
    logic            ifault_o, dfault_o;
    logic [9:0]      fsr_o;
    logic [VA_W-1:0] far_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [VA_W-1:0] exp_far = '0;

    always #4 clk = ~clk;

    mmu_access_guard #(.VA_W(VA_W)) i_mmu_access_guard (.*);

    // {kind[1:0], super, field[2:0], nofault, traps_en, rwx[2:0], err[1:0]}
    localparam logic [12:0] VEC [14] = '{
        {2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'b100, 2'd0},
        {2'd1, 1'b1, 3'd1, 1'b0, 1'b1, 3'b110, 2'd0},
        {2'd2, 1'b0, 3'd2, 1'b0, 1'b1, 3'b101, 2'd0},
        {2'd1, 1'b0, 3'd0, 1'b0, 1'b1, 3'b000, 2'd2},
        {2'd0, 1'b0, 3'd6, 1'b0, 1'b1, 3'b000, 2'd3},
        {2'd0, 1'b1, 3'd6, 1'b0, 1'b1, 3'b101, 2'd0},
        {2'd2, 1'b1, 3'd4, 1'b0, 1'b1, 3'b001, 2'd0},
        {2'd1, 1'b1, 3'd5, 1'b0, 1'b1, 3'b110, 2'd0},
        {2'd0, 1'b0, 3'd7, 1'b1, 1'b1, 3'b000, 2'd0},
        {2'd0, 1'b0, 3'd5, 1'b0, 1'b1, 3'b100, 2'd0},
        {2'd2, 1'b0, 3'd0, 1'b0, 1'b0, 3'b000, 2'd2},
        {2'd1, 1'b1, 3'd3, 1'b1, 1'b1, 3'b111, 2'd0},
        {2'd2, 1'b1, 3'd1, 1'b1, 1'b1, 3'b000, 2'd2},
        {2'd1, 1'b0, 3'd4, 1'b0, 1'b1, 3'b000, 2'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] kind, input logic sup, input logic [2:0] field,
                         input logic [1:0] lvl, input logic [2:0] wk, input logic nf,
                         input logic ten, input logic [VA_W-1:0] va, input logic rd);
        @(negedge clk);
        req_valid_i  = 1'b1;
        req_kind_i   = kind;
        req_super_i  = sup;
        acc_field_i  = field;
        walk_level_i = lvl;
        walk_kind_i  = wk;
        nofault_en_i = nf;
        traps_en_i   = ten;
        req_vaddr_i  = va;
        fsr_rd_i     = rd;
        @(negedge clk);
        req_valid_i = 1'b0;
        walk_kind_i = '0;
        fsr_rd_i    = 1'b0;
    endtask

    task automatic read_clear();
        @(negedge clk);
        fsr_rd_i = 1'b1;
        @(negedge clk);
        fsr_rd_i = 1'b0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 fsr", 32'(fsr_o), 0);
        check("R1 far", far_o, 0);
        check("R1 rsp", {rsp_valid_o, rsp_rd_o, rsp_wr_o, rsp_ex_o, rsp_ok_o, ifault_o, dfault_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {fsr_o, rsp_valid_o, ifault_o, dfault_o}, 0);

        for (int i = 0; i < 14; i++) begin
            logic [1:0] k; logic s; logic [2:0] f; logic nf, ten; logic [2:0] rwx; logic [1:0] e;
            logic [2:0] idx; logic cap, trap; logic [2:0] er; logic [9:0] ef; logic [VA_W-1:0] va;
            {k, s, f, nf, ten, rwx, e} = VEC[i];
            idx  = {k == 2'd1, k == 2'd2, s};
            cap  = (e != 0);
            trap = cap && !nf && ten;
            er   = trap ? 3'b000 : (cap ? 3'b111 : rwx);
            ef   = cap ? 10'((idx << 5) | (e << 2) | 2) : 10'd0;
            va   = 32'h1000_0000 + 32'(i) * 32'h1000;
            if (cap) exp_far = va;
            issue(k, s, f, 2'd0, 3'd0, nf, ten, va, 1'b0);
            check("R3 rights", {rsp_rd_o, rsp_wr_o, rsp_ex_o}, er);
            check("R2 R4 fsr", 32'(fsr_o), 32'(ef));
            check("R8 pulses", {ifault_o, dfault_o}, {trap && k == 2'd2, trap && k != 2'd2});
            check("R10 ok", {rsp_valid_o, rsp_ok_o}, {1'b1, !trap});
            check("R7 far", far_o, exp_far);
            read_clear();
            check("R9 cleared", 32'(fsr_o), 0);
        end

        // R5: walk error, level 2, kind 1, supervisor load
        issue(2'd0, 1'b1, 3'd3, 2'd2, 3'd1, 1'b0, 1'b1, 32'hABCD_E000, 1'b0);
        check("R5 walk fsr", 32'(fsr_o), 32'h226);
        check("R8 walk dfault", {ifault_o, dfault_o}, 2'b01);
        check("R7 walk far", far_o, 32'hABCD_E000);

        // R6: second fault before any read, user fetch walk level 1 kind 4
        issue(2'd2, 1'b0, 3'd3, 2'd1, 3'd4, 1'b0, 1'b1, 32'h0000_5000, 1'b0);
        check("R6 overflow fsr", 32'(fsr_o), 32'h153);
        check("R8 ifault", {ifault_o, dfault_o}, 2'b10);

        // R9: read strobe together with a user store protection fault
        @(negedge clk);
        check("R9 value visible during read", 32'(fsr_o), 32'h153);
        issue(2'd1, 1'b0, 3'd0, 2'd0, 3'd0, 1'b0, 1'b1, 32'h0000_7000, 1'b1);
        check("R9 fresh capture", 32'(fsr_o), 32'h08A);

        // R7 and R4: allowed and ignored requests leave both registers alone
        issue(2'd0, 1'b1, 3'd1, 2'd0, 3'd0, 1'b0, 1'b1, 32'h0000_9000, 1'b0);
        check("R7 far held", far_o, 32'h0000_7000);
        issue(2'd1, 1'b0, 3'd0, 2'd0, 3'd0, 1'b1, 1'b1, 32'h0000_B000, 1'b0);
        check("R4 fsr unchanged", 32'(fsr_o), 32'h08A);
        check("R4 user rights", {rsp_rd_o, rsp_wr_o, rsp_ex_o, rsp_ok_o}, 4'b1001);
        check("R7 far after ignore", far_o, 32'h0000_7000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule